// File: doc/BRIEF.md
# Unaligned Word-Packing DMA Engine

This engine moves a byte stream between a byte-wide device port and a memory that accepts only whole 32-bit words. Software loads a word address and a control word that gives the starting byte offset inside the first word, the direction and an enable. While enabled, the engine takes bytes from the device, packs them into words and writes each completed aligned word to memory. In the other direction it fetches words and streams them out one byte at a time.

The memory port has no byte enables, so a word that is only partly covered by the transfer can never be written without damaging its neighbours. Such words are kept inside the engine instead. Bytes that belong to an unaligned first word collect in a leading holding register. Bytes left over after the last full word collect in a trailing holding register. Each holding register has one valid flag per byte lane. After clearing the enable, software reads both holding registers and their flags, and merges only the valid lanes into memory itself. The stopped word address points at the word that the trailing bytes belong to.

Top module: `dwp_engine`

## Requirements
- R1: After reset, all four readable registers read zero, and `dev_in_ready`, `dev_out_valid`, `mem_wr_en` and `mem_rd_en` are low.
- R2: Register select values are 0 for the word address, 1 for control, 2 for leading-hold data and 3 for trailing-hold data. Writing the word address loads it into bits [ADDR_W-1:0] and clears every valid flag of both holding registers.
- R3: The control layout is bits [1:0] byte offset, bit 2 direction (1 = device to memory) and bit 3 enable. A read of control also returns the leading-hold lane valid flags in bits [7:4] and the trailing-hold lane valid flags in bits [11:8]. Writing control with the enable set starts a fresh transfer and clears all valid flags.
- R4: Toward memory, bytes fill lanes little-endian, starting at the programmed offset. A full word is written at the current word address, with the first of its bytes in bits [7:0], in the cycle after its lane-3 byte is accepted. The word address then reads one higher.
- R5: With a nonzero offset, the bytes of the first word go to the leading hold register in lanes offset..3, with their valid flags set, and are never written to memory. Lane 0 of that register is never valid. The address advances once the lane-3 byte arrives.
- R6: Bytes after the last full word go to the trailing hold register from lane 0 upward, with their valid flags set, and are not written to memory. Lane 3 of that register is never valid. The word address then names the word they belong to.
- R7: A transfer that stops before reaching lane 3 of an unaligned first word leaves the address unchanged and the trailing valid flags clear.
- R8: While the enable is clear, `dev_in_ready`, `dev_out_valid` and `mem_rd_en` stay low. Offered bytes are ignored, and the address and holding registers keep their values.
- R9: Toward the device, the word at the current address is read with `mem_rd_data` expected one cycle after `mem_rd_en`. Its bytes are sent from lane offset up to lane 3, and then each following word is sent from lane 0. The address advances after each lane-3 byte is sent.
- R10: Only the selected direction is active: in the memory-to-device direction `dev_in_ready` and `mem_wr_en` stay low, and in the device-to-memory direction `dev_out_valid` and `mem_rd_en` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select for writes |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_sel | input | 2 | Register select for reads |
| reg_rd_data | output | 32 | Register read data (combinational) |
| dev_in_valid | input | 1 | Device byte offered toward memory |
| dev_in_data | input | 8 | Device byte toward memory |
| dev_in_ready | output | 1 | Engine accepts a device byte |
| dev_out_valid | output | 1 | Engine offers a byte to the device |
| dev_out_data | output | 8 | Byte toward the device |
| dev_out_ready | input | 1 | Device accepts the offered byte |
| mem_wr_en | output | 1 | Full-word memory write |
| mem_wr_addr | output | ADDR_W | Word address of the write |
| mem_wr_data | output | 32 | Word written |
| mem_rd_en | output | 1 | Word read request |
| mem_rd_addr | output | ADDR_W | Word address of the read |
| mem_rd_data | input | 32 | Read word, valid one cycle after the request |

## Verification
The hardest state to reach is a stopped transfer in which both holding registers carry partial bytes at once. This needs an offset of three, so that the leading register takes a single lane-3 byte. It then needs a full word written in between, followed by two trailing bytes. The stimulus builds this in two bursts, one byte and then six, and checks the address and flags after each burst. It also offers a byte after the stop to confirm that the frozen state is not disturbed.

// File: rtl/dwp_pkg.sv
package dwp_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = $clog2(LANES);
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lanes_t;
    typedef logic [LANE_W-1:0] lane_t;

    typedef enum logic [1:0] {
        REG_ADDR  = 2'd0,
        REG_CTRL  = 2'd1,
        REG_HOLD0 = 2'd2,
        REG_HOLD1 = 2'd3
    } reg_sel_e;

    // [3] enable, [2] toward memory, [1:0] starting byte offset
    typedef struct packed {
        logic  enable;
        logic  to_mem;
        lane_t offset;
    } ctrl_t;

    typedef struct packed {
        word_t  data;
        lanes_t vld;
    } hold_t;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_FETCH,
        RD_WAIT,
        RD_SEND
    } rd_state_e;

    function automatic word_t put_byte(word_t w, lane_t lane, byte_t b);
        word_t r;
        r = w;
        r[int'(lane)*BYTE_W +: BYTE_W] = b;
        return r;
    endfunction

    function automatic byte_t get_byte(word_t w, lane_t lane);
        return w[int'(lane)*BYTE_W +: BYTE_W];
    endfunction
endpackage

// File: rtl/dwp_regfile.sv
module dwp_regfile
    import dwp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  word_t             wr_data,
    input  logic              addr_inc,
    output logic [ADDR_W-1:0] word_addr,
    output ctrl_t             ctrl,
    output ctrl_t             ctrl_next,
    output logic              addr_load,
    output logic              run_start
);
    logic ctrl_load;
    logic unused_hi;

    assign unused_hi = ^wr_data[WORD_W-1:ADDR_W];
    assign ctrl_next = ctrl_t'(wr_data[3:0]);
    assign addr_load = wr_en && (wr_sel == REG_ADDR);
    assign ctrl_load = wr_en && (wr_sel == REG_CTRL);
    assign run_start = ctrl_load && ctrl_next.enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_addr <= '0;
            ctrl      <= '0;
        end else begin
            if (addr_load)
                word_addr <= wr_data[ADDR_W-1:0];
            else if (addr_inc)
                word_addr <= word_addr + 1'b1;
            if (ctrl_load)
                ctrl <= ctrl_next;
        end
    end
endmodule

// File: rtl/dwp_pack_in.sv
module dwp_pack_in
    import dwp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              start,
    input  lane_t             start_lane,
    input  logic              clear_vld,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic              in_valid,
    input  byte_t             in_data,
    output logic              in_ready,
    output logic              addr_inc,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output word_t             mem_wr_data,
    output hold_t             hold0,
    output hold_t             hold1
);
    lane_t lane_q;
    logic  lead_q;
    logic  take;
    logic  last_lane;

    assign in_ready  = active;
    assign take      = in_valid && in_ready;
    assign last_lane = (lane_q == lane_t'(LANES-1));
    assign addr_inc  = take && last_lane;

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q      <= '0;
            lead_q      <= 1'b0;
            hold0       <= '0;
            hold1       <= '0;
            mem_wr_en   <= 1'b0;
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
        end else begin
            mem_wr_en <= 1'b0;
            if (start) begin
                lane_q <= start_lane;
                lead_q <= (start_lane != '0);
            end else if (take) begin
                lane_q <= lane_q + 1'b1;
                if (last_lane)
                    lead_q <= 1'b0;
                if (lead_q) begin
                    hold0.data         <= put_byte(hold0.data, lane_q, in_data);
                    hold0.vld[lane_q]  <= 1'b1;
                end else if (last_lane) begin
                    mem_wr_en   <= 1'b1;
                    mem_wr_addr <= word_addr;
                    mem_wr_data <= put_byte(hold1.data, lane_q, in_data);
                    hold1.vld   <= '0;
                end else begin
                    hold1.data         <= put_byte(hold1.data, lane_q, in_data);
                    hold1.vld[lane_q]  <= 1'b1;
                end
            end
            if (clear_vld || start) begin
                hold0.vld <= '0;
                hold1.vld <= '0;
            end
        end
    end
endmodule

// File: rtl/dwp_unpack_out.sv
module dwp_unpack_out
    import dwp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              start,
    input  lane_t             start_lane,
    input  logic [ADDR_W-1:0] word_addr,
    input  word_t             mem_rd_data,
    input  logic              out_ready,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              out_valid,
    output byte_t             out_data,
    output logic              addr_inc
);
    rd_state_e state_q;
    lane_t     lane_q;
    word_t     buf_q;
    logic      send;
    logic      last_lane;

    assign mem_rd_en   = active && (state_q == RD_FETCH);
    assign mem_rd_addr = word_addr;
    assign out_valid   = active && (state_q == RD_SEND);
    assign out_data    = get_byte(buf_q, lane_q);
    assign send        = out_valid && out_ready;
    assign last_lane   = (lane_q == lane_t'(LANES-1));
    assign addr_inc    = send && last_lane;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RD_IDLE;
            lane_q  <= '0;
            buf_q   <= '0;
        end else if (start) begin
            state_q <= RD_FETCH;
            lane_q  <= start_lane;
        end else if (!active) begin
            state_q <= RD_IDLE;
        end else begin
            case (state_q)
                RD_FETCH: state_q <= RD_WAIT;
                RD_WAIT: begin
                    buf_q   <= mem_rd_data;
                    state_q <= RD_SEND;
                end
                RD_SEND: begin
                    if (send) begin
                        lane_q <= lane_q + 1'b1;
                        if (last_lane)
                            state_q <= RD_FETCH;
                    end
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dwp_engine.sv
module dwp_engine
    import dwp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_sel,
    input  logic [31:0]       reg_wr_data,
    input  logic [1:0]        reg_rd_sel,
    output logic [31:0]       reg_rd_data,
    input  logic              dev_in_valid,
    input  logic [7:0]        dev_in_data,
    output logic              dev_in_ready,
    output logic              dev_out_valid,
    output logic [7:0]        dev_out_data,
    input  logic              dev_out_ready,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [31:0]       mem_rd_data
);
    logic [ADDR_W-1:0] word_addr;
    ctrl_t             ctrl_q;
    ctrl_t             ctrl_next;
    logic              addr_load;
    logic              run_start;
    logic              inc_in;
    logic              inc_out;
    logic              active_in;
    logic              active_out;
    hold_t             hold0;
    hold_t             hold1;

    assign active_in  = ctrl_q.enable && ctrl_q.to_mem;
    assign active_out = ctrl_q.enable && !ctrl_q.to_mem;

    dwp_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .wr_sel    (reg_sel_e'(reg_wr_sel)),
        .wr_data   (reg_wr_data),
        .addr_inc  (inc_in || inc_out),
        .word_addr (word_addr),
        .ctrl      (ctrl_q),
        .ctrl_next (ctrl_next),
        .addr_load (addr_load),
        .run_start (run_start)
    );

    dwp_pack_in #(.ADDR_W(ADDR_W)) u_pack (
        .clk         (clk),
        .rst         (rst),
        .active      (active_in),
        .start       (run_start && ctrl_next.to_mem),
        .start_lane  (ctrl_next.offset),
        .clear_vld   (addr_load || run_start),
        .word_addr   (word_addr),
        .in_valid    (dev_in_valid),
        .in_data     (dev_in_data),
        .in_ready    (dev_in_ready),
        .addr_inc    (inc_in),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .hold0       (hold0),
        .hold1       (hold1)
    );

    dwp_unpack_out #(.ADDR_W(ADDR_W)) u_unpack (
        .clk         (clk),
        .rst         (rst),
        .active      (active_out),
        .start       (run_start && !ctrl_next.to_mem),
        .start_lane  (ctrl_next.offset),
        .word_addr   (word_addr),
        .mem_rd_data (mem_rd_data),
        .out_ready   (dev_out_ready),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .out_valid   (dev_out_valid),
        .out_data    (dev_out_data),
        .addr_inc    (inc_out)
    );

    always_comb begin
        case (reg_sel_e'(reg_rd_sel))
            REG_ADDR:  reg_rd_data = {{(WORD_W-ADDR_W){1'b0}}, word_addr};
            REG_CTRL:  reg_rd_data = {{(WORD_W-12){1'b0}}, hold1.vld, hold0.vld, ctrl_q};
            REG_HOLD0: reg_rd_data = hold0.data;
            default:   reg_rd_data = hold1.data;
        endcase
    end
endmodule

// File: rtl/dwp_engine_chk.sv
module dwp_engine_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic              dev_in_valid,
    input logic              dev_in_ready,
    input logic              dev_out_valid,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic              mem_rd_en,
    input logic              ctrl_en,
    input logic [ADDR_W-1:0] word_addr,
    input logic [3:0]        h0_vld,
    input logic [3:0]        h1_vld
);
    // R5
    hold0_lane0_chk: assert property (@(posedge clk) disable iff (rst) !h0_vld[0]);

    // R6
    hold1_lane3_chk: assert property (@(posedge clk) disable iff (rst) !h1_vld[3]);

    // R4
    write_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> $past(dev_in_valid && dev_in_ready));

    // R4
    addr_advanced_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && !$past(reg_wr_en)) |-> (word_addr == mem_wr_addr + 1'b1));

    // R8
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |-> (!dev_in_ready && !dev_out_valid && !mem_rd_en));

    // R8
    stopped_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_en && $past(!ctrl_en) && !$past(reg_wr_en)) |-> ($stable(word_addr) && $stable(h0_vld) && $stable(h1_vld)));

    // R10
    one_direction_chk: assert property (@(posedge clk) disable iff (rst)
        !(dev_in_ready && (dev_out_valid || mem_rd_en)));
endmodule

bind dwp_engine dwp_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_wr_en     (reg_wr_en),
    .dev_in_valid  (dev_in_valid),
    .dev_in_ready  (dev_in_ready),
    .dev_out_valid (dev_out_valid),
    .mem_wr_en     (mem_wr_en),
    .mem_wr_addr   (mem_wr_addr),
    .mem_rd_en     (mem_rd_en),
    .ctrl_en       (ctrl_q.enable),
    .word_addr     (word_addr),
    .h0_vld        (hold0.vld),
    .h1_vld        (hold1.vld)
);

// File: tb/tb_dwp_engine.sv
module tb_dwp_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr_en = 1'b0;
    logic [1:0]    reg_wr_sel = '0;
    logic [31:0]   reg_wr_data = '0;
    logic [1:0]    reg_rd_sel = '0;
    logic [31:0]   reg_rd_data;
    logic          dev_in_valid = 1'b0;
    logic [7:0]    dev_in_data = '0;
    logic          dev_in_ready;
    logic          dev_out_valid;
    logic [7:0]    dev_out_data;
    logic          dev_out_ready = 1'b0;
    logic          mem_wr_en;
    logic [AW-1:0] mem_wr_addr;
    logic [31:0]   mem_wr_data;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [31:0]   mem_rd_q = '0;

    logic [31:0] mem [16];
    logic        mem_fill = 1'b0;
    int          wr_count = 0;
    int          vectors = 0;
    int          fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dwp_engine #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_q)
    );

    function automatic logic [31:0] pat(int k);
        return {8'(k*16+3), 8'(k*16+2), 8'(k*16+1), 8'(k*16)};
    endfunction

    always @(posedge clk) begin
        if (mem_fill) begin
            for (int k = 0; k < 16; k++) mem[k] <= pat(k);
            wr_count <= 0;
        end else if (mem_wr_en) begin
            mem[mem_wr_addr[3:0]] <= mem_wr_data;
            wr_count <= wr_count + 1;
        end
        if (mem_rd_en) mem_rd_q <= mem[mem_rd_addr[3:0]];
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [31:0] d);
        reg_rd_sel = sel;
        #1;
        d = reg_rd_data;
    endtask

    task automatic fill_mem();
        mem_fill = 1'b1;
        @(negedge clk);
        mem_fill = 1'b0;
    endtask

    task automatic send_bytes(input int n, input logic [7:0] first);
        for (int i = 0; i < n; i++) begin
            dev_in_valid = 1'b1;
            dev_in_data  = first + 8'(i);
            @(negedge clk);
        end
        dev_in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int s = 0; s < 4; s++) begin
            rd_reg(2'(s), v);
            check("R1 register after reset", v, 32'h0);
        end
        check("R1 idle outputs", {28'h0, dev_in_ready, dev_out_valid, mem_wr_en, mem_rd_en}, 32'h0);
    endtask

    task automatic t_aligned_in();
        logic [31:0] v;
        fill_mem();
        wr_reg(2'd0, 32'd4);
        wr_reg(2'd1, 32'hC);
        send_bytes(9, 8'h10);
        check("R4 first full word", mem[4], 32'h13121110);
        check("R4 second full word", mem[5], 32'h17161514);
        check("R6 trailing word not written", mem[6], pat(6));
        check("R4 write count", 32'(wr_count), 32'd2);
        rd_reg(2'd0, v); check("R6 address at trailing word", v, 32'd6);
        rd_reg(2'd3, v); check("R6 trailing lane0 byte", {24'h0, v[7:0]}, 32'h18);
        rd_reg(2'd1, v); check("R3 control readback with flags", v, 32'h10C);
        wr_reg(2'd1, 32'h0);
        check("R8 ready low when stopped", {31'h0, dev_in_ready}, 32'h0);
        send_bytes(1, 8'h99);
        rd_reg(2'd1, v); check("R8 flags frozen", v, 32'h100);
        rd_reg(2'd0, v); check("R8 address frozen", v, 32'd6);
        rd_reg(2'd3, v); check("R8 trailing data frozen", {24'h0, v[7:0]}, 32'h18);
        check("R8 no write while stopped", 32'(wr_count), 32'd2);
    endtask

    task automatic t_unaligned_in();
        logic [31:0] v;
        fill_mem();
        wr_reg(2'd0, 32'd8);
        rd_reg(2'd1, v); check("R2 address write clears flags", v, 32'h0);
        wr_reg(2'd1, 32'hF);
        send_bytes(1, 8'h20);
        rd_reg(2'd0, v); check("R5 address past leading word", v, 32'd9);
        rd_reg(2'd2, v); check("R5 leading lane3 byte", {24'h0, v[31:24]}, 32'h20);
        rd_reg(2'd1, v); check("R5 leading flags", v, 32'h08F);
        send_bytes(6, 8'h21);
        check("R4 middle word written", mem[9], 32'h24232221);
        check("R5 leading word untouched", mem[8], pat(8));
        check("R5 single write", 32'(wr_count), 32'd1);
        rd_reg(2'd0, v); check("R6 address names trailing word", v, 32'd10);
        rd_reg(2'd3, v); check("R6 trailing bytes", {16'h0, v[15:0]}, 32'h2625);
        rd_reg(2'd1, v); check("R6 both flag sets", v, 32'h38F);
        wr_reg(2'd1, 32'h0);
    endtask

    task automatic t_short_in();
        logic [31:0] v;
        fill_mem();
        wr_reg(2'd0, 32'd12);
        wr_reg(2'd1, 32'hD);
        send_bytes(2, 8'h30);
        rd_reg(2'd0, v); check("R7 address unchanged", v, 32'd12);
        rd_reg(2'd1, v); check("R7 only leading flags", v, 32'h06D);
        rd_reg(2'd2, v); check("R7 leading bytes", {16'h0, v[23:8]}, 32'h3130);
        check("R7 no memory write", 32'(wr_count), 32'd0);
        wr_reg(2'd1, 32'h0);
    endtask

    task automatic t_out();
        logic [31:0] v;
        logic [7:0]  got [6];
        logic [7:0]  exp [6];
        int          n = 0;
        int          guard = 0;
        logic        in_seen = 1'b0;
        exp = '{8'h22, 8'h23, 8'h30, 8'h31, 8'h32, 8'h33};
        fill_mem();
        wr_reg(2'd0, 32'd2);
        dev_out_ready = 1'b1;
        wr_reg(2'd1, 32'hA);
        while (n < 6 && guard < 200) begin
            if (dev_in_ready) in_seen = 1'b1;
            if (dev_out_valid) begin
                got[n] = dev_out_data;
                n++;
            end
            guard++;
            @(negedge clk);
        end
        dev_out_ready = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 byte count", 32'(n), 32'd6);
        for (int i = 0; i < 6; i++)
            check("R9 streamed byte", {24'h0, got[i]}, {24'h0, exp[i]});
        rd_reg(2'd0, v); check("R9 address after two lane3 bytes", v, 32'd4);
        check("R10 no memory write toward device", 32'(wr_count), 32'd0);
        check("R10 input port idle toward device", {31'h0, in_seen}, 32'h0);
        wr_reg(2'd1, 32'h0);
        check("R8 output valid drops on stop", {31'h0, dev_out_valid}, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_aligned_in();
        t_unaligned_in();
        t_short_in();
        t_out();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule